// File: doc/BRIEF.md
# Decode Stage Stall and Squash Controller

This block governs the flow of instruction slots from a fetch stage into a rename stage for several hardware threads. Each thread has its own lane, and each lane has its own status machine and a small skid store. Instructions are opaque payloads. A lane accepts up to `W` slots per cycle from fetch and forwards them to rename one cycle later. Rename can hold a thread back with a stall request and can release it with a release request. A later commit stage can flush a thread at any time.

While a thread is held, every arriving slot is parked in its skid store. When the hold is released, the lane drains the store, oldest first, before direct forwarding resumes. Slots that arrive during the drain are queued behind the parked ones. The lane tells fetch when it starts holding and when it has finished draining, using one-cycle pulses.

A branch misprediction found at decode is reported through a separate input. It flushes the thread and produces a registered redirect toward fetch.

Top module: `decode_ctl`

## Requirements
- R1: After a synchronous active-high reset, every thread's status (`thr_st`, 3 bits per thread; Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4) is Idle, and all output valids and pulses are 0.
- R2: In Idle, Running or Squashing with no flush and no stall, the valid arrival slots (packed from slot 0 upward) appear on the rename outputs in the same slots one cycle later. A thread leaves Idle for Running on its first arrival, and leaves Squashing for Running on the next cycle.
- R3: A stall request from rename sets a sticky per-thread stall flag. While the flag is set, arrivals go into the skid store in order, nothing is forwarded, and the status becomes Blocked. `fe_blk` pulses for one cycle only on entry to Blocked.
- R4: A release request clears the flag. A Blocked thread then drains its skid store, at most W slots per cycle and oldest first, and appends new arrivals behind the parked slots. Its status is Unblocking while slots remain.
- R5: In the cycle the store becomes empty during a drain, the status goes to Running and `fe_unb` pulses for one cycle.
- R6: A commit flush empties the thread's skid store, discards that cycle's arrivals and sets Squashing. It takes priority over a stall request and over a decode redirect in the same cycle. If the thread was Blocked or Unblocking, `fe_unb` pulses and `fe_blk` stays low.
- R7: A decode misprediction without a commit flush flushes the thread as in R6. One cycle later it raises `rd_vld` with the given sequence number and target. `rd_taken` is the given taken flag, forced to 1 when the transfer is unconditional.
- R8: Skid store occupancy never exceeds SKID. A full store's contents drain complete and in order.
- R9: Threads are independent: one thread's flush, stall or drain does not change another thread's status or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | NTHR*W | Arrival slot valids, W per thread |
| in_dat | input | NTHR*W*DW | Arrival slot payloads |
| ren_blk | input | NTHR | Stall request from rename, per thread |
| ren_unb | input | NTHR | Release request from rename, per thread |
| cm_sq | input | NTHR | Flush request from commit, per thread |
| mp_vld | input | NTHR | Decode misprediction found, per thread |
| mp_seq | input | NTHR*SEQW | Sequence number of the mispredicted instruction |
| mp_tgt | input | NTHR*AW | Correct branch target |
| mp_taken | input | NTHR | Taken direction of the branch |
| mp_uncond | input | NTHR | Branch is an unconditional transfer |
| out_vld | output | NTHR*W | Slot valids toward rename |
| out_dat | output | NTHR*W*DW | Slot payloads toward rename |
| fe_blk | output | NTHR | One-cycle hold notice to fetch |
| fe_unb | output | NTHR | One-cycle release notice to fetch |
| rd_vld | output | NTHR | Redirect toward fetch is valid |
| rd_seq | output | NTHR*SEQW | Redirect sequence number |
| rd_tgt | output | NTHR*AW | Redirect address |
| rd_taken | output | NTHR | Redirect taken flag |
| thr_st | output | NTHR*3 | Per-thread status code |

## Verification
The functions that collide are the commit flush and the rename stall, since both can arrive for a thread in one cycle while slots are arriving. The bench drives a flush, a stall request and two arrival slots together on a Running thread. It expects Squashing, no hold pulse to fetch and no forwarded slots. On the next cycle it sends a release and expects normal forwarding, which shows that the flush won and the sticky flag was not disturbed. The same approach covers a flush landing while a thread is Blocked, and a commit flush that coincides with a decode misprediction.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    TS_IDLE  = 3'd0,
    TS_RUN   = 3'd1,
    TS_HOLD  = 3'd2,
    TS_DRAIN = 3'd3,
    TS_FLUSH = 3'd4
  } tstate_e;
endpackage

// File: rtl/dsc_skid.sv
module dsc_skid #(
  parameter int W    = 2,
  parameter int DW   = 16,
  parameter int SKID = 8,
  localparam int CW  = $clog2(W + 1),
  localparam int LW  = $clog2(SKID + 1),
  localparam int PW  = $clog2(SKID)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic [CW-1:0]   n_push,
  input  logic [W*DW-1:0] din,
  input  logic [CW-1:0]   n_pop,
  output logic [W*DW-1:0] dout,
  output logic [LW-1:0]   lvl
);
  // SKID must be a power of two so that the pointers wrap by themselves
  logic [DW-1:0] mem [SKID];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (!flush && CW'(i) < n_push)
        mem[wptr + PW'(i)] <= din[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      lvl  <= '0;
    end else begin
      wptr <= wptr + PW'(n_push);
      rptr <= rptr + PW'(n_pop);
      lvl  <= lvl + LW'(n_push) - LW'(n_pop);
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++)
      dout[i*DW +: DW] = mem[rptr + PW'(i)];
  end
endmodule

// File: rtl/dsc_lane.sv
module dsc_lane
  import dsc_pkg::*;
#(
  parameter int W    = 2,
  parameter int DW   = 16,
  parameter int SKID = 8,
  parameter int SEQW = 16,
  parameter int AW   = 32,
  localparam int CW  = $clog2(W + 1),
  localparam int LW  = $clog2(SKID + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    in_vld,
  input  logic [W*DW-1:0] in_dat,
  input  logic            ren_blk,
  input  logic            ren_unb,
  input  logic            cm_sq,
  input  logic            mp_vld,
  input  logic [SEQW-1:0] mp_seq,
  input  logic [AW-1:0]   mp_tgt,
  input  logic            mp_taken,
  input  logic            mp_uncond,
  output logic [W-1:0]    out_vld,
  output logic [W*DW-1:0] out_dat,
  output logic            fe_blk,
  output logic            fe_unb,
  output logic            rd_vld,
  output logic [SEQW-1:0] rd_seq,
  output logic [AW-1:0]   rd_tgt,
  output logic            rd_taken,
  output logic [2:0]      st,
  output logic [LW-1:0]   lvl
);
  tstate_e         st_q, st_n;
  logic            stall_q, stall_n;
  logic [CW-1:0]   n_in, push, pop;
  logic            flush, fb_n, fu_n, rd_n;
  logic [W-1:0]    ov_n;
  logic [W*DW-1:0] od_n, sk_dout;

  dsc_skid #(.W(W), .DW(DW), .SKID(SKID)) u_skid (
    .clk(clk), .rst(rst), .flush(flush), .n_push(push), .din(in_dat),
    .n_pop(pop), .dout(sk_dout), .lvl(lvl)
  );

  always_comb begin
    n_in = '0;
    for (int i = 0; i < W; i++) n_in = n_in + CW'(in_vld[i]);
    stall_n = stall_q;
    if (ren_blk)      stall_n = 1'b1;
    else if (ren_unb) stall_n = 1'b0;
    st_n  = st_q;
    ov_n  = '0;
    od_n  = out_dat;
    fb_n  = 1'b0;
    fu_n  = 1'b0;
    rd_n  = 1'b0;
    push  = '0;
    pop   = '0;
    flush = 1'b0;
    if (cm_sq || mp_vld) begin
      // flush wins over stall and drain
      flush = 1'b1;
      st_n  = TS_FLUSH;
      fu_n  = (st_q == TS_HOLD) || (st_q == TS_DRAIN);
      rd_n  = !cm_sq;
    end else if (stall_n) begin
      push = n_in;
      st_n = TS_HOLD;
      fb_n = (st_q != TS_HOLD);
    end else if (st_q == TS_HOLD || st_q == TS_DRAIN) begin
      pop  = (int'(lvl) > W) ? CW'(W) : CW'(lvl);
      push = n_in;
      for (int i = 0; i < W; i++) ov_n[i] = (CW'(i) < pop);
      od_n = sk_dout;
      if (int'(lvl) - int'(pop) + int'(n_in) == 0) begin
        st_n = TS_RUN;
        fu_n = 1'b1;
      end else begin
        st_n = TS_DRAIN;
      end
    end else begin
      ov_n = in_vld;
      od_n = in_dat;
      if (st_q != TS_IDLE || n_in != '0) st_n = TS_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= TS_IDLE;
      stall_q  <= 1'b0;
      out_vld  <= '0;
      out_dat  <= '0;
      fe_blk   <= 1'b0;
      fe_unb   <= 1'b0;
      rd_vld   <= 1'b0;
      rd_seq   <= '0;
      rd_tgt   <= '0;
      rd_taken <= 1'b0;
    end else begin
      st_q    <= st_n;
      stall_q <= stall_n;
      out_vld <= ov_n;
      out_dat <= od_n;
      fe_blk  <= fb_n;
      fe_unb  <= fu_n;
      rd_vld  <= rd_n;
      if (rd_n) begin
        rd_seq   <= mp_seq;
        rd_tgt   <= mp_tgt;
        rd_taken <= mp_taken | mp_uncond;
      end
    end
  end

  assign st = st_q;
endmodule

// File: rtl/decode_ctl.sv
module decode_ctl #(
  parameter int NTHR = 2,
  parameter int W    = 2,
  parameter int DW   = 16,
  parameter int SKID = 8,
  parameter int SEQW = 16,
  parameter int AW   = 32,
  localparam int LW  = $clog2(SKID + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NTHR*W-1:0]    in_vld,
  input  logic [NTHR*W*DW-1:0] in_dat,
  input  logic [NTHR-1:0]      ren_blk,
  input  logic [NTHR-1:0]      ren_unb,
  input  logic [NTHR-1:0]      cm_sq,
  input  logic [NTHR-1:0]      mp_vld,
  input  logic [NTHR*SEQW-1:0] mp_seq,
  input  logic [NTHR*AW-1:0]   mp_tgt,
  input  logic [NTHR-1:0]      mp_taken,
  input  logic [NTHR-1:0]      mp_uncond,
  output logic [NTHR*W-1:0]    out_vld,
  output logic [NTHR*W*DW-1:0] out_dat,
  output logic [NTHR-1:0]      fe_blk,
  output logic [NTHR-1:0]      fe_unb,
  output logic [NTHR-1:0]      rd_vld,
  output logic [NTHR*SEQW-1:0] rd_seq,
  output logic [NTHR*AW-1:0]   rd_tgt,
  output logic [NTHR-1:0]      rd_taken,
  output logic [NTHR*3-1:0]    thr_st
);
  logic [NTHR*LW-1:0] skid_lvl;

  for (genvar t = 0; t < NTHR; t++) begin : g_lane
    dsc_lane #(.W(W), .DW(DW), .SKID(SKID), .SEQW(SEQW), .AW(AW)) u_lane (
      .clk(clk), .rst(rst),
      .in_vld(in_vld[t*W +: W]), .in_dat(in_dat[t*W*DW +: W*DW]),
      .ren_blk(ren_blk[t]), .ren_unb(ren_unb[t]), .cm_sq(cm_sq[t]),
      .mp_vld(mp_vld[t]), .mp_seq(mp_seq[t*SEQW +: SEQW]),
      .mp_tgt(mp_tgt[t*AW +: AW]), .mp_taken(mp_taken[t]),
      .mp_uncond(mp_uncond[t]),
      .out_vld(out_vld[t*W +: W]), .out_dat(out_dat[t*W*DW +: W*DW]),
      .fe_blk(fe_blk[t]), .fe_unb(fe_unb[t]), .rd_vld(rd_vld[t]),
      .rd_seq(rd_seq[t*SEQW +: SEQW]), .rd_tgt(rd_tgt[t*AW +: AW]),
      .rd_taken(rd_taken[t]), .st(thr_st[t*3 +: 3]),
      .lvl(skid_lvl[t*LW +: LW])
    );
  end
endmodule

// File: rtl/dsc_chk.sv
module dsc_chk #(
  parameter int NTHR = 2,
  parameter int W    = 2,
  parameter int SKID = 8,
  localparam int LW  = $clog2(SKID + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [NTHR*W-1:0]  out_vld,
  input logic [NTHR-1:0]    ren_blk,
  input logic [NTHR-1:0]    cm_sq,
  input logic [NTHR-1:0]    mp_vld,
  input logic [NTHR-1:0]    mp_uncond,
  input logic [NTHR-1:0]    fe_blk,
  input logic [NTHR-1:0]    rd_vld,
  input logic [NTHR-1:0]    rd_taken,
  input logic [NTHR*3-1:0]  thr_st,
  input logic [NTHR*LW-1:0] skid_lvl
);
  for (genvar t = 0; t < NTHR; t++) begin : g_t
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
      int'(skid_lvl[t*LW +: LW]) <= SKID);
    a_r3_stall_silences: assert property (@(posedge clk) disable iff (rst)
      (ren_blk[t] && !cm_sq[t] && !mp_vld[t]) |=> (out_vld[t*W +: W] == '0));
    a_r3_block_single_pulse: assert property (@(posedge clk) disable iff (rst)
      fe_blk[t] |=> !fe_blk[t]);
    a_r6_flush_state: assert property (@(posedge clk) disable iff (rst)
      cm_sq[t] |=> (thr_st[t*3 +: 3] == 3'd4 && out_vld[t*W +: W] == '0 && !rd_vld[t]));
    a_r7_uncond_taken: assert property (@(posedge clk) disable iff (rst)
      (mp_vld[t] && mp_uncond[t] && !cm_sq[t]) |=> (rd_vld[t] && rd_taken[t]));
  end
endmodule

bind decode_ctl dsc_chk #(.NTHR(NTHR), .W(W), .SKID(SKID)) u_chk (
  .clk(clk), .rst(rst), .out_vld(out_vld), .ren_blk(ren_blk), .cm_sq(cm_sq),
  .mp_vld(mp_vld), .mp_uncond(mp_uncond), .fe_blk(fe_blk), .rd_vld(rd_vld),
  .rd_taken(rd_taken), .thr_st(thr_st), .skid_lvl(skid_lvl)
);

// File: tb/sim_decode_ctl.sv
module sim_decode_ctl;
  localparam int NTHR = 2, W = 2, DW = 16, SKID = 8, SEQW = 16, AW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [NTHR*W-1:0]    in_vld;
  logic [NTHR*W*DW-1:0] in_dat;
  logic [NTHR-1:0]      ren_blk, ren_unb, cm_sq, mp_vld, mp_taken, mp_uncond;
  logic [NTHR*SEQW-1:0] mp_seq;
  logic [NTHR*AW-1:0]   mp_tgt;
  logic [NTHR*W-1:0]    out_vld;
  logic [NTHR*W*DW-1:0] out_dat;
  logic [NTHR-1:0]      fe_blk, fe_unb, rd_vld, rd_taken;
  logic [NTHR*SEQW-1:0] rd_seq;
  logic [NTHR*AW-1:0]   rd_tgt;
  logic [NTHR*3-1:0]    thr_st;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  decode_ctl #(.NTHR(NTHR), .W(W), .DW(DW), .SKID(SKID), .SEQW(SEQW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_dat(in_dat), .ren_blk(ren_blk),
    .ren_unb(ren_unb), .cm_sq(cm_sq), .mp_vld(mp_vld), .mp_seq(mp_seq),
    .mp_tgt(mp_tgt), .mp_taken(mp_taken), .mp_uncond(mp_uncond),
    .out_vld(out_vld), .out_dat(out_dat), .fe_blk(fe_blk), .fe_unb(fe_unb),
    .rd_vld(rd_vld), .rd_seq(rd_seq), .rd_tgt(rd_tgt), .rd_taken(rd_taken),
    .thr_st(thr_st)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    in_vld = '0; in_dat = '0; ren_blk = '0; ren_unb = '0; cm_sq = '0;
    mp_vld = '0; mp_seq = '0; mp_tgt = '0; mp_taken = '0; mp_uncond = '0;
  endtask

  // thread 0 arrivals: n slots, payloads a and b
  task automatic put0(int n, logic [15:0] a, logic [15:0] b);
    in_vld[1:0] = (n == 2) ? 2'b11 : (n == 1) ? 2'b01 : 2'b00;
    in_dat[31:0] = {b, a};
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // thread 0 outputs after a cycle: valids, slot0, slot1, status
  task automatic look0(string tag, logic [1:0] v, logic [15:0] a, logic [15:0] b, logic [2:0] s);
    chk({tag, " vld"}, 64'(out_vld[1:0]), 64'(v));
    if (v[0]) chk({tag, " slot0"}, 64'(out_dat[15:0]), 64'(a));
    if (v[1]) chk({tag, " slot1"}, 64'(out_dat[31:16]), 64'(b));
    chk({tag, " state"}, 64'(thr_st[2:0]), 64'(s));
  endtask

  task automatic t_reset();
    chk("R1 status", 64'(thr_st), 64'd0);
    chk("R1 valids", 64'({out_vld, fe_blk, fe_unb, rd_vld}), 64'd0);
  endtask

  task automatic t_run();
    clr(); put0(2, 16'hA1, 16'hA2); step();
    look0("R2 pair", 2'b11, 16'hA1, 16'hA2, 3'd1);
    clr(); put0(1, 16'hA3, 16'h0); step();
    look0("R2 single", 2'b01, 16'hA3, 16'h0, 3'd1);
    clr(); step();
    look0("R2 empty", 2'b00, 16'h0, 16'h0, 3'd1);
  endtask

  task automatic t_block();
    clr(); ren_blk[0] = 1'b1; put0(2, 16'h1, 16'h2); step();
    look0("R3 enter", 2'b00, 0, 0, 3'd2);
    chk("R3 fe_blk pulse", 64'(fe_blk[0]), 64'd1);
    clr(); put0(1, 16'h3, 16'h0); step();
    look0("R3 held", 2'b00, 0, 0, 3'd2);
    chk("R3 fe_blk once", 64'(fe_blk[0]), 64'd0);
    clr(); put0(2, 16'h4, 16'h5); step();
    look0("R3 held2", 2'b00, 0, 0, 3'd2);
    clr(); ren_unb[0] = 1'b1; step();
    look0("R4 drain1", 2'b11, 16'h1, 16'h2, 3'd3);
    clr(); put0(1, 16'h6, 16'h0); step();
    look0("R4 drain2", 2'b11, 16'h3, 16'h4, 3'd3);
    chk("R5 no early unb", 64'(fe_unb[0]), 64'd0);
    clr(); step();
    look0("R5 drain3", 2'b11, 16'h5, 16'h6, 3'd1);
    chk("R5 fe_unb pulse", 64'(fe_unb[0]), 64'd1);
    clr(); step();
    chk("R5 fe_unb ends", 64'(fe_unb[0]), 64'd0);
  endtask

  task automatic t_fill();
    clr(); ren_blk[0] = 1'b1; put0(2, 16'h30, 16'h31); step();
    for (int k = 1; k < 4; k++) begin
      clr(); put0(2, 16'(16'h30 + 2*k), 16'(16'h31 + 2*k)); step();
    end
    look0("R8 full held", 2'b00, 0, 0, 3'd2);
    for (int k = 0; k < 4; k++) begin
      clr(); if (k == 0) ren_unb[0] = 1'b1; step();
      look0("R8 full drain", 2'b11, 16'(16'h30 + 2*k), 16'(16'h31 + 2*k),
            (k == 3) ? 3'd1 : 3'd3);
    end
    chk("R8 final unb", 64'(fe_unb[0]), 64'd1);
  endtask

  task automatic t_squash();
    clr(); ren_blk[0] = 1'b1; put0(2, 16'h11, 16'h12); step();
    clr(); cm_sq[0] = 1'b1; ren_unb[0] = 1'b1; step();
    look0("R6 flush blocked", 2'b00, 0, 0, 3'd4);
    chk("R6 fe_unb on flush", 64'(fe_unb[0]), 64'd1);
    clr(); put0(1, 16'h13, 16'h0); step();
    look0("R6 parked discarded", 2'b01, 16'h13, 16'h0, 3'd1);
    clr(); step();
    look0("R6 nothing left", 2'b00, 0, 0, 3'd1);
    // flush, stall and arrivals together on a running thread
    clr(); cm_sq[0] = 1'b1; ren_blk[0] = 1'b1; put0(2, 16'h21, 16'h22); step();
    look0("R6 flush beats stall", 2'b00, 0, 0, 3'd4);
    chk("R6 no block pulse", 64'(fe_blk[0]), 64'd0);
    clr(); ren_unb[0] = 1'b1; put0(1, 16'h23, 16'h0); step();
    look0("R6 resume", 2'b01, 16'h23, 16'h0, 3'd1);
  endtask

  task automatic t_redirect();
    clr(); mp_vld[0] = 1'b1; mp_seq[15:0] = 16'h0055; mp_tgt[31:0] = 32'h1000_0040;
    mp_uncond[0] = 1'b1; put0(1, 16'h40, 16'h0); step();
    chk("R7 rd_vld", 64'(rd_vld[0]), 64'd1);
    chk("R7 uncond taken", 64'(rd_taken[0]), 64'd1);
    chk("R7 seq", 64'(rd_seq[15:0]), 64'h55);
    chk("R7 tgt", 64'(rd_tgt[31:0]), 64'h1000_0040);
    look0("R7 flushes", 2'b00, 0, 0, 3'd4);
    clr(); mp_vld[0] = 1'b1; mp_seq[15:0] = 16'h0056; step();
    chk("R7 cond not taken", 64'(rd_taken[0]), 64'd0);
    chk("R7 seq2", 64'(rd_seq[15:0]), 64'h56);
    clr(); mp_vld[0] = 1'b1; mp_taken[0] = 1'b1; cm_sq[0] = 1'b1; step();
    chk("R6 commit beats redirect", 64'(rd_vld[0]), 64'd0);
    clr(); step();
    chk("R7 rd pulse ends", 64'(rd_vld[0]), 64'd0);
  endtask

  task automatic t_threads();
    clr(); cm_sq[0] = 1'b1; in_vld[3:2] = 2'b01; in_dat[47:32] = 16'hB1; step();
    chk("R9 t0 flushed", 64'(thr_st[2:0]), 64'd4);
    chk("R9 t1 running", 64'(thr_st[5:3]), 64'd1);
    chk("R9 t1 vld", 64'(out_vld[3:2]), 64'd1);
    chk("R9 t1 data", 64'(out_dat[47:32]), 64'hB1);
    clr(); ren_blk[1] = 1'b1; put0(1, 16'h50, 16'h0); step();
    look0("R9 t0 unaffected", 2'b01, 16'h50, 16'h0, 3'd1);
    chk("R9 t1 blocked", 64'(thr_st[5:3]), 64'd2);
    clr(); ren_unb[1] = 1'b1; step();
  endtask

  initial begin
    clr();
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_run();
    t_block();
    t_fill();
    t_squash();
    t_redirect();
    t_threads();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule